// File: doc/BRIEF.md
# CPU Endpoint FIFO Write Selector

This block lets a CPU register interface load bytes into the transmit and receive byte queues of five endpoints: the control endpoint EP0 and four general endpoints a, b, c and d. The CPU first writes a target-select register. It then writes bytes to a single data-port address, and each byte lands in the FIFO of the selected endpoint. A free-space readout, split into a high byte and a low byte, tells the CPU how many more bytes the selected FIFO can take.

Writes from the CPU must not overlap traffic from the USB side or the DMA side. Each endpoint has a static direction bit. The block rejects a data-port write when the target is an OUT endpoint whose forced-NAK input is low. It also rejects a data-port write when the target is an IN endpoint while DMA is running. Both rejections, and writes that find the FIFO full, are recorded in sticky flags.

A drain port lets the consumer side pop bytes from any endpoint FIFO, so that the fill levels can move in both directions.

Top module: `cpu_ep_wr_sel`

## Requirements
- R1: After reset, the select register reads 0x00, both sticky flags are 0, and the free-space readout equals DEPTH (8).
- R2: The select register is at address 0. Bits 3:0 are writable and read back. Bits 7:4 always read 0.
- R3: Select bits 0, 1, 2 and 3 choose endpoints a, b, c and d, which have endpoint indices 1 to 4. When several bits are set, the highest set bit decides the target.
- R4: When select bits 3:0 are all 0, the target is EP0 (index 0).
- R5: A write to address 1 (the data port) pushes the byte into the target FIFO. The drain port returns the bytes of each endpoint in the order they were pushed. Address 1 reads 0.
- R6: Address 2 reads the high byte and address 3 reads the low byte of the 16-bit free space, which is DEPTH minus the target's fill count. The readout shows a new value in the cycle right after a push or a pop.
- R7: While the write-access enable is 0, writes to the select register and to the data port have no effect.
- R8: Bit i of the direction input gives endpoint i's direction (1 = IN, 0 = OUT). A data-port write whose target is OUT with its forced-NAK bit at 0, or IN while DMA is busy, is dropped and sets the sticky conflict flag.
- R9: A data-port write that does not collide but finds the target FIFO full is dropped and sets the sticky overflow flag. The free space then reads 0. The full test uses the fill count before any drain in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 2 | Register address: 0 select, 1 data port, 2 free high, 3 free low |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Combinational read data for cpu_addr |
| wr_access_en | input | 1 | Write-access enable for the select register and the data port |
| ep_is_in | input | 5 | Direction per endpoint, bit 0 EP0, bits 1 to 4 a to d; 1 = IN |
| ep_force_nak | input | 5 | Forced-NAK status per endpoint, same bit order |
| dma_busy | input | 1 | DMA engine running |
| drain_en | input | 1 | Pop one byte from the FIFO chosen by drain_ep |
| drain_ep | input | 3 | Endpoint index to drain (0 to 4) |
| drain_data | output | 8 | Head byte of the FIFO chosen by drain_ep |
| drain_valid | output | 1 | The FIFO chosen by drain_ep is not empty |
| conflict_flag | output | 1 | Sticky: a data-port write was dropped because of a collision |
| overflow_flag | output | 1 | Sticky: a data-port write was dropped because the FIFO was full |

## Verification
A CPU data-port push and a drain-side pop can hit the same endpoint FIFO in the same clock edge. When they do, the fill count must stay the same and the byte order must hold. A full FIFO must still refuse the push even though a slot is leaving in that edge.

The random phase provokes this by issuing drains in the same cycle as data-port writes, both aimed at the selected endpoint, and by filling FIFOs to the edge. A bench model holds per-endpoint queues and counts. It judges the free-space readout after every step, the byte order on the drain port, and both sticky flags.

// File: rtl/cpuep_pkg.sv
package cpuep_pkg;
    localparam int NUM_EP  = 5;
    localparam int NUM_SEL = NUM_EP - 1;
    localparam int IDX_W   = $clog2(NUM_EP);

    typedef logic [IDX_W-1:0] ep_idx_t;

    localparam logic [1:0] ADDR_SEL     = 2'd0;
    localparam logic [1:0] ADDR_DATA    = 2'd1;
    localparam logic [1:0] ADDR_FREE_HI = 2'd2;
    localparam logic [1:0] ADDR_FREE_LO = 2'd3;

    typedef struct packed {
        logic [NUM_SEL-1:0] sel;
        logic               conflict;
        logic               overflow;
    } ctl_t;
endpackage

// File: rtl/ep_prio_resolve.sv
module ep_prio_resolve
    import cpuep_pkg::*;
(
    input  logic [NUM_SEL-1:0] sel_bits,
    output ep_idx_t            target
);
    // Scan upward, so the highest set bit wins; none set means EP0.
    always_comb begin
        target = '0;
        for (int i = 0; i < NUM_SEL; i++) begin
            if (sel_bits[i]) target = ep_idx_t'(i + 1);
        end
    end
endmodule

// File: rtl/ep_byte_fifo.sv
module ep_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] dout_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    typedef struct packed {
        logic [PW-1:0] wr_ptr;
        logic [PW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;
    assign dout_o  = mem_q[st_q.rd_ptr];
    assign count_o = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        if (pop_ok)  st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr_ptr] <= din_i;
    end

    // R9: fill level never passes the depth
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R9: a push into a full queue with no pop leaves the level unchanged
    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> (count_o == CW'(DEPTH)));
    // R5: pop from an empty queue leaves it empty when nothing is pushed
    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/cpu_ep_wr_sel.sv
module cpu_ep_wr_sel
    import cpuep_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int FREE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              wr_access_en,
    input  logic [NUM_EP-1:0] ep_is_in,
    input  logic [NUM_EP-1:0] ep_force_nak,
    input  logic              dma_busy,
    input  logic              drain_en,
    input  logic [2:0]        drain_ep,
    output logic [7:0]        drain_data,
    output logic              drain_valid,
    output logic              conflict_flag,
    output logic              overflow_flag
);
    localparam int CW = $clog2(DEPTH + 1);

    ctl_t ctl_d, ctl_q;
    ep_idx_t target;

    logic [NUM_EP-1:0] push_vec, pop_vec, full_vec, empty_vec;
    logic [7:0]        dout_arr [NUM_EP];
    logic [CW-1:0]     cnt_arr  [NUM_EP];

    logic              sel_wr, data_wr, collide, tgt_full, drain_ok;
    logic [FREE_W-1:0] free_space;

    ep_prio_resolve u_resolve (
        .sel_bits (ctl_q.sel),
        .target   (target)
    );

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        ep_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (push_vec[g]),
            .pop_i   (pop_vec[g]),
            .din_i   (cpu_wdata),
            .dout_o  (dout_arr[g]),
            .count_o (cnt_arr[g]),
            .full_o  (full_vec[g]),
            .empty_o (empty_vec[g])
        );
    end

    assign sel_wr   = cpu_wr && wr_access_en && (cpu_addr == ADDR_SEL);
    assign data_wr  = cpu_wr && wr_access_en && (cpu_addr == ADDR_DATA);
    assign collide  = ep_is_in[target] ? dma_busy : !ep_force_nak[target];
    assign tgt_full = full_vec[target];
    assign drain_ok = drain_en && (drain_ep < 3'(NUM_EP));

    always_comb begin
        push_vec = '0;
        pop_vec  = '0;
        if (data_wr && !collide && !tgt_full) push_vec[target] = 1'b1;
        if (drain_ok) pop_vec[drain_ep[IDX_W-1:0]] = 1'b1;
    end

    always_comb begin
        ctl_d = ctl_q;
        if (sel_wr) ctl_d.sel = cpu_wdata[NUM_SEL-1:0];
        if (data_wr && collide)              ctl_d.conflict = 1'b1;
        if (data_wr && !collide && tgt_full) ctl_d.overflow = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign free_space = FREE_W'(DEPTH) - FREE_W'(cnt_arr[target]);

    always_comb begin
        case (cpu_addr)
            ADDR_SEL:     cpu_rdata = {{(8-NUM_SEL){1'b0}}, ctl_q.sel};
            ADDR_FREE_HI: cpu_rdata = free_space[FREE_W-1 -: 8];
            ADDR_FREE_LO: cpu_rdata = free_space[7:0];
            default:      cpu_rdata = 8'h00;
        endcase
    end

    assign drain_data    = drain_ok ? dout_arr[drain_ep[IDX_W-1:0]] : 8'h00;
    assign drain_valid   = drain_ok && !empty_vec[drain_ep[IDX_W-1:0]];
    assign conflict_flag = ctl_q.conflict;
    assign overflow_flag = ctl_q.overflow;

    // R3: resolved target is always a valid endpoint index
    p_target_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        target < ep_idx_t'(NUM_EP));
    // R4: empty selection resolves to EP0
    p_zero_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.sel == '0) |-> (target == '0));
    // R5: at most one FIFO takes a CPU byte per cycle
    p_one_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_vec));
    // R7: disabled access leaves the selection untouched
    p_ignore_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_access_en |=> $stable(ctl_q.sel));
    // R8: the conflict flag never clears
    p_conflict_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_flag |=> conflict_flag);
    // R9: the overflow flag never clears
    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_flag |=> overflow_flag);
endmodule

// File: tb/tb_cpu_ep_wr_sel.sv
`timescale 1ns/1ps
module tb_cpu_ep_wr_sel;
    localparam int D = 8;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       cpu_wr = 0;
    logic [1:0] cpu_addr = 0;
    logic [7:0] cpu_wdata = 0;
    logic [7:0] cpu_rdata;
    logic       wr_access_en = 1;
    logic [4:0] ep_is_in = 5'b00000;
    logic [4:0] ep_force_nak = 5'b11111;
    logic       dma_busy = 0;
    logic       drain_en = 0;
    logic [2:0] drain_ep = 0;
    logic [7:0] drain_data;
    logic       drain_valid;
    logic       conflict_flag, overflow_flag;

    int checks = 0;
    int errors = 0;

    logic [3:0] m_sel = 0;
    logic       m_conf = 0, m_ovf = 0;
    logic [7:0] mq [5][D];
    int         m_head [5];
    int         m_cnt  [5];

    always #5 clk = ~clk;

    cpu_ep_wr_sel dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_target(input logic [3:0] s);
        for (int i = 3; i >= 0; i--) if (s[i]) return i + 1;
        return 0;
    endfunction

    // Applies the effect of one data-port push/drain edge to the model.
    task automatic model_edge(input bit wr, input logic [1:0] a, input logic [7:0] d,
                              input bit dr, input int dep);
        int t;
        bit col, full_before;
        t = exp_target(m_sel);
        full_before = (m_cnt[t] == D);
        if (dr && dep < 5 && m_cnt[dep] > 0) begin
            m_head[dep] = (m_head[dep] + 1) % D;
            m_cnt[dep]--;
        end
        if (wr && wr_access_en) begin
            if (a == 2'd0) m_sel = d[3:0];
            else if (a == 2'd1) begin
                col = ep_is_in[t] ? dma_busy : !ep_force_nak[t];
                if (col) m_conf = 1;
                else if (full_before) m_ovf = 1;
                else begin
                    mq[t][(m_head[t] + m_cnt[t]) % D] = d;
                    m_cnt[t]++;
                end
            end
        end
    endtask

    task automatic op(input bit wr, input logic [1:0] a, input logic [7:0] d,
                      input bit dr, input int dep, input string tag);
        @(negedge clk);
        cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        drain_en = dr; drain_ep = 3'(dep);
        #1;
        if (dr && dep < 5 && m_cnt[dep] > 0)
            chk(drain_valid && drain_data == mq[dep][m_head[dep]], tag,
                int'(drain_data), int'(mq[dep][m_head[dep]]));
        @(posedge clk);
        model_edge(wr, a, d, dr, dep);
        #1;
        cpu_wr = 0; drain_en = 0;
    endtask

    task automatic check_free(input string tag);
        int f;
        int e;
        @(negedge clk);
        cpu_addr = 2'd2; #1; f = int'(cpu_rdata) << 8;
        cpu_addr = 2'd3; #1; f = f | int'(cpu_rdata);
        e = D - m_cnt[exp_target(m_sel)];
        chk(f == e, tag, f, e);
    endtask

    task automatic check_flags(input string tag);
        @(negedge clk); #1;
        chk(conflict_flag == m_conf, {tag, " conflict"}, int'(conflict_flag), int'(m_conf));
        chk(overflow_flag == m_ovf, {tag, " overflow"}, int'(overflow_flag), int'(m_ovf));
    endtask

    task automatic check_sel(input string tag);
        @(negedge clk); cpu_addr = 2'd0; #1;
        chk(cpu_rdata == {4'h0, m_sel}, tag, int'(cpu_rdata), int'({4'h0, m_sel}));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        for (int i = 0; i < 5; i++) begin m_head[i] = 0; m_cnt[i] = 0; end
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        check_sel("R1 select after reset");
        check_flags("R1");
        check_free("R1 free after reset");

        // R2 reserved bits read zero
        op(1, 2'd0, 8'hF5, 0, 0, "R2");
        check_sel("R2 select readback");
        // data port reads zero (R5)
        @(negedge clk); cpu_addr = 2'd1; #1;
        chk(cpu_rdata == 8'h00, "R5 data port read", int'(cpu_rdata), 0);

        // R3 priority: 0x06 -> endpoint c (index 3)
        op(1, 2'd0, 8'h06, 0, 0, "R3");
        op(1, 2'd1, 8'hA3, 0, 0, "R3");
        check_free("R3 free after push to c");
        op(0, 2'd0, 0, 1, 3, "R3 drain c gets byte");
        op(0, 2'd0, 0, 1, 2, "R3 endpoint b untouched");
        @(negedge clk); drain_en = 1; drain_ep = 3'd2; #1;
        chk(!drain_valid, "R3 endpoint b empty", int'(drain_valid), 0);
        drain_en = 0;

        // R4 all-zero select -> EP0
        op(1, 2'd0, 8'h00, 0, 0, "R4");
        op(1, 2'd1, 8'h11, 0, 0, "R4");
        op(1, 2'd1, 8'h22, 0, 0, "R4");
        check_free("R4 free on EP0");
        // R5 ordering
        op(0, 2'd0, 0, 1, 0, "R5 first byte");
        op(0, 2'd0, 0, 1, 0, "R5 second byte");
        // R6 free updates right after push
        op(1, 2'd1, 8'h33, 0, 0, "R6");
        check_free("R6 free after push");

        // R9 fill EP0 then overflow
        for (int i = 0; i < D; i++) op(1, 2'd1, 8'(8'h40 + i), 0, 0, "R9");
        check_free("R9 free reads zero when full");
        check_flags("R9 after overflow");
        // push and drain on full FIFO together: push still refused (R9)
        op(1, 2'd1, 8'h77, 1, 0, "R9 simultaneous");
        check_free("R9 free after full push+drain");

        // R7 disabled access
        wr_access_en = 0;
        op(1, 2'd0, 8'h08, 0, 0, "R7");
        check_sel("R7 select unchanged");
        op(1, 2'd1, 8'h99, 0, 0, "R7");
        check_free("R7 free unchanged");
        wr_access_en = 1;

        // R8 collisions: a is IN with DMA busy
        op(1, 2'd0, 8'h01, 0, 0, "R8");
        ep_is_in = 5'b00010; dma_busy = 1;
        op(1, 2'd1, 8'h55, 0, 0, "R8");
        check_free("R8 free unchanged on IN collision");
        check_flags("R8 after IN collision");
        dma_busy = 0;
        // b is OUT with forced-NAK low
        op(1, 2'd0, 8'h02, 0, 0, "R8");
        ep_force_nak = 5'b11011;
        op(1, 2'd1, 8'h56, 0, 0, "R8");
        check_free("R8 free unchanged on OUT collision");
        ep_force_nak = 5'b11111;
        op(1, 2'd1, 8'h57, 0, 0, "R8");
        check_free("R8 push allowed with NAK set");

        // random phase
        for (int it = 0; it < 1500; it++) begin
            int kind;
            int ep;
            kind = int'($urandom % 10);
            ep = int'($urandom % 5);
            wr_access_en = ($urandom % 8) != 0;
            dma_busy = ($urandom % 6) == 0;
            ep_force_nak = ($urandom % 6 == 0) ? 5'($urandom) : 5'b11111;
            ep_is_in = 5'($urandom);
            if (kind < 2)      op(1, 2'd0, 8'($urandom), 0, 0, "R3 random select");
            else if (kind < 6) op(1, 2'd1, 8'($urandom), ($urandom % 2) == 1,
                                  exp_target(m_sel), "R5 random push+drain");
            else if (kind < 8) op(0, 2'd0, 0, 1, ep, "R5 random drain");
            else               op(1, 2'($urandom), 8'($urandom), 0, 0, "R7 random access");
            check_free("R6 random free");
            if (it % 50 == 0) begin
                check_flags("R8 R9 random flags");
                check_sel("R2 random select");
            end
        end
        check_flags("R8 R9 final flags");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule